// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit converts a two-part logical address into a 32-bit linear address. The first part is a 16-bit selector that names a descriptor. The second part is a 32-bit offset. The unit has six segment registers. Each register caches the descriptor that was last loaded into it successfully. The descriptors themselves live in two small on-chip tables: a global table that all code shares, and a local table that belongs to the running task. A write port fills both tables.

Loading a selector into a segment register works in three steps. The unit reads the named descriptor, checks it against the target register and the current privilege, and then either fills the cache entry or reports a fault. While a load is in progress the unit is busy, and it ignores any other load or any translation request. After a register is loaded, a translation request names that register and gives an offset. One cycle later the unit returns either the base-plus-offset address or a fault code. Each translation checks three things: that the register holds a usable descriptor, that the access privilege is allowed, and that the offset is within the segment limit.

Top module: `seg_xlate_unit`

## Requirements
- R1: Selector fields:
  - bits 15:3 are the descriptor index;
  - bit 2 selects the local table when 1 and the global table when 0;
  - bits 1:0 are the requested privilege.
  A table write with `tbl_we_i` stores `tbl_wdata_i` at `tbl_idx_i` in the local table when `tbl_local_i` is 1, otherwise in the global table. The packed layout of a descriptor is {type[57:56], ring[55:54], present[53], gran[52], base[51:20], limit[19:0]}. Type codes are 0 code, 1 data, 2 stack. Rings run from 0, the most privileged, to 3.
- R2: Load timing and stalls.
  - A load is accepted on a rising edge where `ld_valid_i` is high and `busy_o` is low.
  - `busy_o` is then high for exactly two cycles.
  - `ld_done_o` pulses for one cycle after the second edge that follows acceptance, together with `ld_fault_o`.
  - Loads and translation requests that arrive while `busy_o` is high are ignored and produce no result.
- R3: Null selector.
  - A null selector is global table index 0 (bit 2 clear, index 0).
  - It loads without a fault into registers ES=0, DS=3, FS=4 and GS=5.
  - Loading it into CS=1 or SS=2 raises a protection fault (code 2).
  - A translation through a register that holds the null selector, or that has not been loaded since reset, returns null fault code 4.
- R4: A non-null selector whose index is at or above the depth of the chosen table raises a protection fault on load.
- R5: Privilege and type checks on load. Any failure raises a protection fault.
  - Data registers (ES, DS, FS, GS) need a data or stack type and max(current ring, requested ring) <= descriptor ring.
  - SS needs stack type, requested ring equal to current ring, and descriptor ring equal to current ring.
  - CS needs code type and descriptor ring <= current ring.
- R6: A descriptor that passes the R3 to R5 checks but has its present flag clear raises a not-present fault, code 1.
- R7: A load that faults leaves the target segment register's previous contents unchanged.
- R8: The effective limit is the 20-bit limit when gran is 0, and (limit << 12) | 0xFFF when gran is 1. An offset above the effective limit returns limit fault code 3.
- R9: An accepted translation with no fault sets `res_valid_o` for one cycle after the accepting edge. It returns `res_lin_o` = (base + offset) mod 2^32 with fault code 0.
- R10: A translation through any register other than CS, made while the current ring is numerically greater than the cached descriptor ring, returns a protection fault.
- R11: Register codes 6 and 7 raise a protection fault on load and on translation.
- R12: A faulting translation returns `res_lin_o` = 0. Translation faults are ranked as follows: bad register code, then null, then privilege, then limit.
- R13: A translation accepted on the same edge as a load uses the register contents from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpl_i | input | 2 | Current privilege ring |
| tbl_we_i | input | 1 | Descriptor table write enable |
| tbl_local_i | input | 1 | Write targets the local table |
| tbl_idx_i | input | 3 | Table write index |
| tbl_wdata_i | input | 58 | Packed descriptor to write |
| ld_valid_i | input | 1 | Selector load request |
| ld_seg_i | input | 3 | Target segment register code |
| ld_sel_i | input | 16 | Selector to load |
| busy_o | output | 1 | Load in progress; requests stalled |
| ld_done_o | output | 1 | Load finished pulse |
| ld_fault_o | output | 3 | Load fault code |
| acc_valid_i | input | 1 | Translation request |
| acc_seg_i | input | 3 | Segment register used |
| acc_off_i | input | 32 | Offset |
| res_valid_o | output | 1 | Translation result pulse |
| res_lin_o | output | 32 | Linear address |
| res_fault_o | output | 3 | Translation fault code |

## Verification
Assertions watch several properties on every cycle:
- the load sequence advances through its read and update steps in order, and a done pulse follows each update;
- no translation result appears in the cycle after the unit was busy;
- a faulted load leaves the register cache untouched;
- a faulting translation returns a zero address;
- a clean translation never exceeds its limit;
- an illegal register code always faults.

Other behaviour depends on the data in the tables, and only the bench scenarios can show it. The bench sweeps every register code, both tables, every index up to past the table depth, and every requested ring. It checks the classification of each load fault, the limit expansion for byte and page granularity, and the result at and just past each limit. It also checks linear addresses that wrap past 2^32 and the ordering when a load and a translation arrive on the same edge.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_N  = 6;
  localparam int SEG_W  = 3;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int ADDR_W = 32;
  localparam int LIM_W  = 20;
  localparam int FLT_W  = 3;

  localparam logic [SEG_W-1:0] SEG_ES = 3'd0;
  localparam logic [SEG_W-1:0] SEG_CS = 3'd1;
  localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
  localparam logic [SEG_W-1:0] SEG_DS = 3'd3;
  localparam logic [SEG_W-1:0] SEG_FS = 3'd4;
  localparam logic [SEG_W-1:0] SEG_GS = 3'd5;

  typedef enum logic [1:0] {
    DT_CODE  = 2'd0,
    DT_DATA  = 2'd1,
    DT_STACK = 2'd2,
    DT_RSVD  = 2'd3
  } dtype_e;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE  = 3'd0,
    FLT_NP    = 3'd1,
    FLT_PROT  = 3'd2,
    FLT_LIMIT = 3'd3,
    FLT_NULL  = 3'd4
  } fault_e;

  typedef struct packed {
    dtype_e            dtype;
    logic [1:0]        ring;
    logic              present;
    logic              gran;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef struct packed {
    logic              usable;
    logic [1:0]        ring;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] eff_lim;
  } cache_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  desc_t            wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output desc_t            rdata_o,
  output logic             rhit_o
);
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(DEPTH);

  desc_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    desc_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (we_i && (widx_i < DEPTH_L) && (widx_i[TW-1:0] == TW'(g))) ent_q <= wdata_i;
    end
    assign mem[g] = ent_q;
  end

  assign rhit_o  = ridx_i < DEPTH_L;
  assign rdata_o = rhit_o ? mem[ridx_i[TW-1:0]] : '0;
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SEG_W-1:0]       wseg_i,
  input  cache_t                 wentry_i,
  output cache_t [SEG_N-1:0]     ent_o
);
  for (genvar g = 0; g < SEG_N; g++) begin : g_reg
    cache_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (we_i && wseg_i == SEG_W'(g)) ent_q <= wentry_i;
    end
    assign ent_o[g] = ent_q;
  end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cpl_i,
  input  logic             ld_valid_i,
  input  logic [SEG_W-1:0] ld_seg_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  desc_t            gdt_rd_i,
  input  logic             gdt_hit_i,
  input  desc_t            ldt_rd_i,
  input  logic             ldt_hit_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             ld_done_o,
  output logic [FLT_W-1:0] ld_fault_o,
  output logic             wr_en_o,
  output logic [SEG_W-1:0] wr_seg_o,
  output cache_t           wr_entry_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_UPDATE} st_e;

  st_e              state_q;
  logic [SEG_W-1:0] seg_q;
  logic [SEL_W-1:0] sel_q;
  desc_t            desc_q;
  logic             hit_q;

  fault_e     fault_c;
  logic       null_c;
  logic [1:0] rpl_c;
  logic [1:0] eff_pl_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      seg_q      <= '0;
      sel_q      <= '0;
      desc_q     <= '0;
      hit_q      <= 1'b0;
      ld_done_o  <= 1'b0;
      ld_fault_o <= '0;
    end else begin
      ld_done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (ld_valid_i) begin
          seg_q   <= ld_seg_i;
          sel_q   <= ld_sel_i;
          state_q <= ST_READ;
        end
        ST_READ: begin
          desc_q  <= sel_q[2] ? ldt_rd_i : gdt_rd_i;
          hit_q   <= sel_q[2] ? ldt_hit_i : gdt_hit_i;
          state_q <= ST_UPDATE;
        end
        ST_UPDATE: begin
          ld_done_o  <= 1'b1;
          ld_fault_o <= fault_c;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign rd_idx_o = sel_q[15:3];

  always_comb begin
    rpl_c    = sel_q[1:0];
    eff_pl_c = (cpl_i > rpl_c) ? cpl_i : rpl_c;
    null_c   = !sel_q[2] && (sel_q[15:3] == '0);
    fault_c  = FLT_NONE;
    if (seg_q >= SEG_W'(SEG_N)) begin
      fault_c = FLT_PROT;
    end else if (null_c) begin
      if (seg_q == SEG_CS || seg_q == SEG_SS) fault_c = FLT_PROT;
    end else if (!hit_q) begin
      fault_c = FLT_PROT;
    end else begin
      case (seg_q)
        SEG_CS: if (desc_q.dtype != DT_CODE || desc_q.ring > cpl_i) fault_c = FLT_PROT;
        SEG_SS: if (desc_q.dtype != DT_STACK || rpl_c != cpl_i || desc_q.ring != cpl_i)
                  fault_c = FLT_PROT;
        default: if (!(desc_q.dtype == DT_DATA || desc_q.dtype == DT_STACK) ||
                     eff_pl_c > desc_q.ring) fault_c = FLT_PROT;
      endcase
      if (fault_c == FLT_NONE && !desc_q.present) fault_c = FLT_NP;
    end
  end

  always_comb begin
    wr_entry_o.usable  = !null_c;
    wr_entry_o.ring    = desc_q.ring;
    wr_entry_o.base    = desc_q.base;
    wr_entry_o.eff_lim = desc_q.gran ? {desc_q.limit, 12'hFFF}
                                     : {{(ADDR_W-LIM_W){1'b0}}, desc_q.limit};
  end

  assign wr_en_o  = (state_q == ST_UPDATE) && (fault_c == FLT_NONE);
  assign wr_seg_o = seg_q;

  AST_READ_TO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ) |=> (state_q == ST_UPDATE)); // R2
  AST_UPDATE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UPDATE) |=> (ld_done_o && !busy_o)); // R2
  AST_NP_ONLY_ABSENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_done_o && ld_fault_o == FLT_NP) |-> !desc_q.present); // R6
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          cpl_i,
  input  logic                busy_i,
  input  logic                acc_valid_i,
  input  logic [SEG_W-1:0]    acc_seg_i,
  input  logic [ADDR_W-1:0]   acc_off_i,
  input  cache_t [SEG_N-1:0]  ent_i,
  output logic                res_valid_o,
  output logic [ADDR_W-1:0]   res_lin_o,
  output logic [FLT_W-1:0]    res_fault_o
);
  cache_t            cur_c;
  fault_e            fault_c;
  logic              accept_c;
  logic [ADDR_W-1:0] sum_c;

  assign accept_c = acc_valid_i && !busy_i;

  always_comb begin
    cur_c = '0;
    if (acc_seg_i < SEG_W'(SEG_N)) cur_c = ent_i[acc_seg_i];
    fault_c = FLT_NONE;
    if (acc_seg_i >= SEG_W'(SEG_N))                   fault_c = FLT_PROT;
    else if (!cur_c.usable)                           fault_c = FLT_NULL;
    else if (acc_seg_i != SEG_CS && cpl_i > cur_c.ring) fault_c = FLT_PROT;
    else if (acc_off_i > cur_c.eff_lim)               fault_c = FLT_LIMIT;
    sum_c = cur_c.base + acc_off_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_lin_o   <= '0;
      res_fault_o <= '0;
    end else begin
      res_valid_o <= accept_c;
      if (accept_c) begin
        res_fault_o <= fault_c;
        res_lin_o   <= (fault_c == FLT_NONE) ? sum_c : '0;
      end
    end
  end

  AST_STALL_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !res_valid_o); // R2
  AST_FAULT_ZERO_LIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o != FLT_NONE) |-> (res_lin_o == '0)); // R12
  AST_LIMIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o == FLT_NONE) |-> ($past(acc_off_i) <= $past(cur_c.eff_lim))); // R8
  AST_BAD_SEG_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_c && acc_seg_i >= SEG_W'(SEG_N)) |=> (res_valid_o && res_fault_o == FLT_PROT)); // R11
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_pkg::*;
#(
  parameter int GDT_DEPTH = 8,
  parameter int LDT_DEPTH = 8,
  localparam int TBL_MAX  = (GDT_DEPTH > LDT_DEPTH) ? GDT_DEPTH : LDT_DEPTH,
  localparam int TIDX_W   = (TBL_MAX > 1) ? $clog2(TBL_MAX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          cpl_i,
  input  logic                tbl_we_i,
  input  logic                tbl_local_i,
  input  logic [TIDX_W-1:0]   tbl_idx_i,
  input  logic [DESC_W-1:0]   tbl_wdata_i,
  input  logic                ld_valid_i,
  input  logic [SEG_W-1:0]    ld_seg_i,
  input  logic [SEL_W-1:0]    ld_sel_i,
  output logic                busy_o,
  output logic                ld_done_o,
  output logic [FLT_W-1:0]    ld_fault_o,
  input  logic                acc_valid_i,
  input  logic [SEG_W-1:0]    acc_seg_i,
  input  logic [ADDR_W-1:0]   acc_off_i,
  output logic                res_valid_o,
  output logic [ADDR_W-1:0]   res_lin_o,
  output logic [FLT_W-1:0]    res_fault_o
);
  desc_t              tbl_rd [2];
  logic [1:0]         tbl_hit;
  logic [IDX_W-1:0]   rd_idx;
  logic               cwr_en;
  logic [SEG_W-1:0]   cwr_seg;
  cache_t             cwr_entry;
  cache_t [SEG_N-1:0] cache_ent;

  // table 0 = global, table 1 = local
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    seg_desc_table #(
      .DEPTH (t == 0 ? GDT_DEPTH : LDT_DEPTH)
    ) u_tbl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (tbl_we_i && (tbl_local_i == (t == 1))),
      .widx_i  (IDX_W'(tbl_idx_i)),
      .wdata_i (desc_t'(tbl_wdata_i)),
      .ridx_i  (rd_idx),
      .rdata_o (tbl_rd[t]),
      .rhit_o  (tbl_hit[t])
    );
  end

  seg_loader u_loader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpl_i      (cpl_i),
    .ld_valid_i (ld_valid_i),
    .ld_seg_i   (ld_seg_i),
    .ld_sel_i   (ld_sel_i),
    .gdt_rd_i   (tbl_rd[0]),
    .gdt_hit_i  (tbl_hit[0]),
    .ldt_rd_i   (tbl_rd[1]),
    .ldt_hit_i  (tbl_hit[1]),
    .rd_idx_o   (rd_idx),
    .busy_o     (busy_o),
    .ld_done_o  (ld_done_o),
    .ld_fault_o (ld_fault_o),
    .wr_en_o    (cwr_en),
    .wr_seg_o   (cwr_seg),
    .wr_entry_o (cwr_entry)
  );

  seg_cache u_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cwr_en),
    .wseg_i   (cwr_seg),
    .wentry_i (cwr_entry),
    .ent_o    (cache_ent)
  );

  seg_xlate u_xlate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpl_i       (cpl_i),
    .busy_i      (busy_o),
    .acc_valid_i (acc_valid_i),
    .acc_seg_i   (acc_seg_i),
    .acc_off_i   (acc_off_i),
    .ent_i       (cache_ent),
    .res_valid_o (res_valid_o),
    .res_lin_o   (res_lin_o),
    .res_fault_o (res_fault_o)
  );

  AST_FAULT_KEEPS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_done_o && ld_fault_o != FLT_NONE) |-> $stable(cache_ent)); // R7
endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = '0;
  logic        tbl_we = 1'b0, tbl_local = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [57:0] tbl_wdata = '0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        busy, ld_done;
  logic [2:0]  ld_fault;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_seg = '0;
  logic [31:0] acc_off = '0;
  logic        res_valid;
  logic [31:0] res_lin;
  logic [2:0]  res_fault;

  localparam int F_NONE = 0, F_NP = 1, F_PROT = 2, F_LIM = 3, F_NULL = 4;

  int n_chk = 0, n_fail = 0;

  logic        sh_use  [6];
  logic [1:0]  sh_ring [6];
  logic [31:0] sh_base [6];
  logic [31:0] sh_lim  [6];
  logic        last_faulted = 1'b0;

  always #10 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .cpl_i(cpl),
    .tbl_we_i(tbl_we), .tbl_local_i(tbl_local), .tbl_idx_i(tbl_idx), .tbl_wdata_i(tbl_wdata),
    .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel),
    .busy_o(busy), .ld_done_o(ld_done), .ld_fault_o(ld_fault),
    .acc_valid_i(acc_valid), .acc_seg_i(acc_seg), .acc_off_i(acc_off),
    .res_valid_o(res_valid), .res_lin_o(res_lin), .res_fault_o(res_fault)
  );

  function automatic logic [1:0]  d_type(int ti, int i); return 2'(i % 3); endfunction
  function automatic logic [1:0]  d_ring(int ti, int i); return 2'((i + ti) % 4); endfunction
  function automatic logic        d_pres(int ti, int i); return i != 5; endfunction
  function automatic logic        d_gran(int ti, int i); return (i == 3) || (i == 7); endfunction
  function automatic logic [31:0] d_base(int ti, int i);
    return 32'hF000_0000 + 32'(i) * 32'h0123_4000 + 32'(ti) * 32'h0000_8000;
  endfunction
  function automatic logic [19:0] d_lim(int ti, int i);
    return (i == 7) ? 20'hFFFFF : 20'h00010 + 20'(i) * 20'h00111;
  endfunction
  function automatic logic [31:0] d_eff(int ti, int i);
    return d_gran(ti, i) ? {d_lim(ti, i), 12'hFFF} : {12'h000, d_lim(ti, i)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tbl_write(input int ti, input int i);
    @(negedge clk);
    tbl_we = 1'b1; tbl_local = ti[0]; tbl_idx = 3'(i);
    tbl_wdata = {d_type(ti, i), d_ring(ti, i), d_pres(ti, i), d_gran(ti, i), d_base(ti, i), d_lim(ti, i)};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // one translation; caller is at a negedge
  task automatic do_access(input int seg, input logic [31:0] off);
    int          ef;
    logic [31:0] el;
    string       tag;
    acc_valid = 1'b1; acc_seg = 3'(seg); acc_off = off;
    if (seg > 5)                                   begin ef = F_PROT; tag = "R11"; end
    else if (!sh_use[seg])                         begin ef = F_NULL; tag = "R3";  end
    else if (seg != 1 && cpl > sh_ring[seg])       begin ef = F_PROT; tag = "R10"; end
    else if (off > sh_lim[seg])                    begin ef = F_LIM;  tag = "R8";  end
    else                                           begin ef = F_NONE; tag = "R9";  end
    el = (ef == F_NONE) ? sh_base[seg] + off : 32'h0;
    if (last_faulted) tag = {tag, " R7"};
    @(negedge clk);
    chk(res_valid === 1'b1, {tag, " valid"}, 64'(res_valid), 64'd1);
    chk(res_fault === 3'(ef), {tag, " fault"}, 64'(res_fault), 64'(ef));
    chk(res_lin === el, (ef == F_NONE) ? {tag, " lin"} : {tag, " R12 lin"}, 64'(res_lin), 64'(el));
    acc_valid = 1'b0;
  endtask

  task automatic do_load(input int seg, input int ti, input int idx, input int rpl);
    int    ef;
    int    pl;
    logic  nul;
    logic  [1:0] ty, rg;
    string tag;
    nul = (ti == 0) && (idx == 0);
    ty = d_type(ti, idx); rg = d_ring(ti, idx);
    pl = (int'(cpl) > rpl) ? int'(cpl) : rpl;
    ef = F_NONE; tag = "R1";
    if (seg > 5) begin ef = F_PROT; tag = "R11"; end
    else if (nul) begin ef = (seg == 1 || seg == 2) ? F_PROT : F_NONE; tag = "R3"; end
    else if (idx >= 8) begin ef = F_PROT; tag = "R4"; end
    else begin
      if (seg == 1) begin if (ty != 2'd0 || rg > cpl) ef = F_PROT; end
      else if (seg == 2) begin if (ty != 2'd2 || rpl != int'(cpl) || rg != cpl) ef = F_PROT; end
      else begin if (ty == 2'd0 || pl > int'(rg)) ef = F_PROT; end
      if (ef == F_PROT) tag = "R5";
      else if (!d_pres(ti, idx)) begin ef = F_NP; tag = "R6"; end
    end
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 3'(seg); ld_sel = {13'(idx), 1'(ti), 2'(rpl)};
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy", 64'(busy), 64'd1);
    ld_sel = 16'h0000; ld_seg = 3'd1;               // stray load, must be ignored
    acc_valid = 1'b1; acc_seg = 3'd0; acc_off = '0;  // stray access, must stall
    @(negedge clk);
    chk(res_valid === 1'b0, "R2 stall", 64'(res_valid), 64'd0);
    ld_valid = 1'b0; acc_valid = 1'b0;
    @(negedge clk);
    chk(ld_done === 1'b1 && busy === 1'b0, "R2 done", {62'd0, ld_done, busy}, 64'd2);
    chk(ld_fault === 3'(ef), {tag, " load fault"}, 64'(ld_fault), 64'(ef));
    @(negedge clk);
    chk(ld_done === 1'b0, "R2 stray ignored", 64'(ld_done), 64'd0);
    last_faulted = (ef != F_NONE);
    if (ef == F_NONE && seg <= 5) begin
      sh_use[seg]  = !nul;
      sh_ring[seg] = rg;
      sh_base[seg] = d_base(ti, idx);
      sh_lim[seg]  = d_eff(ti, idx);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int s = 0; s < 6; s++) begin
      sh_use[s] = 1'b0; sh_ring[s] = '0; sh_base[s] = '0; sh_lim[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && ld_done === 1'b0 && res_valid === 1'b0, "R2 reset",
        {61'd0, busy, ld_done, res_valid}, 64'd0);
    for (int s = 0; s < 8; s++) do_access(s, 32'h10);   // R3 unloaded, R11 bad codes

    for (int ti = 0; ti < 2; ti++)
      for (int i = 0; i < 8; i++) tbl_write(ti, i);

    for (int seg = 0; seg < 8; seg++)
      for (int ti = 0; ti < 2; ti++)
        for (int idx = 0; idx < 10; idx++)
          for (int rpl = 0; rpl < 4; rpl++) begin
            cpl = 2'((idx + ti + ((seg == 4) ? 1 : 0)) % 4);
            do_load(seg, ti, idx, rpl);
            do_access(seg, 32'h0);
            if (seg <= 5 && sh_use[seg]) begin
              do_access(seg, sh_lim[seg]);
              if (sh_lim[seg] != 32'hFFFF_FFFF) do_access(seg, sh_lim[seg] + 32'd1);
            end
            do_access(seg, 32'hFFFF_FFF0);
            do_access(3, 32'h4);
          end

    // R13: access on the same edge as a load sees old contents
    cpl = 2'd0;
    do_load(3, 0, 1, 0);
    last_faulted = 1'b0;
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 3'd3; ld_sel = {13'd4, 1'b1, 2'd0};
    acc_valid = 1'b1; acc_seg = 3'd3; acc_off = 32'h4;
    @(negedge clk);
    ld_valid = 1'b0; acc_valid = 1'b0;
    chk(res_valid === 1'b1 && res_lin === d_base(0, 1) + 32'h4, "R13 old contents",
        64'(res_lin), 64'(d_base(0, 1) + 32'h4));
    @(negedge clk);
    @(negedge clk);
    chk(ld_done === 1'b1 && ld_fault === 3'd0, "R13 load done", 64'(ld_fault), 64'd0);
    sh_base[3] = d_base(1, 4); sh_lim[3] = d_eff(1, 4); sh_ring[3] = d_ring(1, 4); sh_use[3] = 1'b1;
    @(negedge clk);
    do_access(3, 32'h4);

    summary();
  end
endmodule